// File: doc/BRIEF.md
# Dual-Mode Interval/Toggle Down-Counting Timer

The block holds a set of identical, independent down-counting timer channels. There are two channels by default, each with a 32-bit count. Software sets up each channel through a small register write port. For each channel it supplies an enable bit, an output-mode bit and a period value. An enabled channel loads its period value and counts down once per clock. When the count runs out, the channel flags a time-out, reloads the period value and keeps counting with no further writes.

Every time-out raises a one-clock interrupt request on that channel's own line. The channel's output pin then does one of two things:

- **Interval mode:** the pin gives a single-clock pulse at each time-out, so the pulse rate is the clock divided by the period value.
- **Toggle mode:** the pin inverts at each time-out, giving a 50% duty square wave at the clock divided by twice the period value. A new toggle run always starts low.

A period value of zero behaves as a value of one. Turning a channel off holds its pin and interrupt low. Turning it back on starts a fresh count.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset every output pin and every interrupt line is low, and all channels are disabled.
- R2: With mode bit 0 (interval), the interrupt line and the output pin pulse high together for one clock per time-out. The spacing between pulses is exactly the period value in clocks. The first pulse comes the period value in clocks after the load cycle.
- R3: With mode bit 1 (toggle), the output pin is low in the cycle after the channel loads. After that it inverts once per time-out, with the period value in clocks between inversions.
- R4: In toggle mode the interrupt line pulses for one clock in exactly those cycles where the output pin has just changed level.
- R5: A period value of 0 acts as 1, so the channel times out on every clock after the load.
- R6: While a channel's enable bit is 0, its output pin and interrupt line stay low. Setting the enable bit again performs a fresh load of the period value.
- R7: A period value written while the channel runs leaves the count in progress alone. It is used from the next reload.
- R8: Channels are independent: writes and activity on one channel do not change the outputs of another.
- R9: Register map: address 0 is the control word, with channel i's enable at bit 2i and its mode at bit 2i+1. Address i+1 holds the period value of channel i. A write lands at the clock edge where wr_en is high and takes effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; counts advance on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, i+1 period of channel i |
| wr_data | input | 32 | Write data |
| tout | output | 2 | Per-channel output pin |
| irq | output | 2 | Per-channel one-clock interrupt request |

## Verification
Two things can happen in the same cycle. A time-out with its reload can coincide with a register write to the same channel: either a new period value or a change of the enable or mode bit. The bench provokes this in two ways. It writes a new period value in the cycles around a known pulse. It also runs a long stretch of seeded random writes against short periods, so that writes keep landing on reload edges. Each cycle, a bench model that counts up from the load decides which period must govern the next interval and what the pin and interrupt must show. Directed gap measurements confirm that the period in progress stays unchanged and that the new period applies from the interval after it.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
   typedef enum logic {
      MODE_INTERVAL = 1'b0,
      MODE_TOGGLE   = 1'b1
   } tmr_mode_e;

   localparam int unsigned CTRL_ADDR = 0;
endpackage

// File: rtl/dmt_regs.sv
module dmt_regs #(
   parameter int unsigned NUM_CH = 2,
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned ADDR_W = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [WIDTH-1:0]        wr_data,
   output logic [NUM_CH-1:0]       ch_en,
   output dmt_pkg::tmr_mode_e      ch_mode [NUM_CH],
   output logic [NUM_CH*WIDTH-1:0] ch_period
);
   localparam int unsigned CTRL_BITS = 2 * NUM_CH;

   if (CTRL_BITS > WIDTH) begin : g_ctrl_fit
      $fatal(1, "control word needs %0d bits, data is %0d", CTRL_BITS, WIDTH);
   end
   if ((NUM_CH + 1) > (1 << ADDR_W)) begin : g_addr_fit
      $fatal(1, "address width %0d too small for %0d channels", ADDR_W, NUM_CH);
   end

   wire ctrl_wr = wr_en && (wr_addr == ADDR_W'(dmt_pkg::CTRL_ADDR));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      wire per_wr = wr_en && (wr_addr == ADDR_W'(i + 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ch_en[i]   <= 1'b0;
            ch_mode[i] <= dmt_pkg::MODE_INTERVAL;
         end else if (ctrl_wr) begin
            ch_en[i]   <= wr_data[2*i];
            ch_mode[i] <= dmt_pkg::tmr_mode_e'(wr_data[2*i+1]);
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      ch_period[i*WIDTH +: WIDTH] <= '0;
         else if (per_wr) ch_period[i*WIDTH +: WIDTH] <= wr_data;
      end
   end
endmodule

// File: rtl/dmt_channel.sv
module dmt_channel #(
   parameter int unsigned WIDTH = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  dmt_pkg::tmr_mode_e mode,
   input  logic [WIDTH-1:0]   period,
   output logic               tout,
   output logic               irq
);
   if (WIDTH < 2) begin : g_width_chk
      $fatal(1, "timer width must be at least 2, got %0d", WIDTH);
   end

   logic [WIDTH-1:0] cnt;
   logic             running;

   wire [WIDTH-1:0] reload_val = (period == '0) ? WIDTH'(1) : period;
   wire             start      = en && !running;
   wire             expire     = en && running && (cnt <= WIDTH'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         running <= 1'b0;
         tout    <= 1'b0;
         irq     <= 1'b0;
      end else if (!en) begin
         running <= 1'b0;
         tout    <= 1'b0;
         irq     <= 1'b0;
      end else if (start) begin
         running <= 1'b1;
         cnt     <= reload_val;
         tout    <= 1'b0;
         irq     <= 1'b0;
      end else begin
         irq <= expire;
         cnt <= expire ? reload_val : cnt - WIDTH'(1);
         if (mode == dmt_pkg::MODE_TOGGLE) tout <= tout ^ expire;
         else                              tout <= expire;
      end
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!tout && !irq)); // R6

   AST_LOAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!tout && !irq)); // R3

   AST_INTERVAL_SAME: assert property (@(posedge clk) disable iff (!rst_n)
      (en && running && mode == dmt_pkg::MODE_INTERVAL) |=> (tout == irq)); // R2

   AST_TOGGLE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (en && running && mode == dmt_pkg::MODE_TOGGLE) |=> (irq == (tout != $past(tout)))); // R4

   AST_NO_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (cnt != '0)); // R5
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer #(
   parameter int unsigned NUM_CH = 2,
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned ADDR_W = $clog2(NUM_CH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WIDTH-1:0]  wr_data,
   output logic [NUM_CH-1:0] tout,
   output logic [NUM_CH-1:0] irq
);
   if (NUM_CH < 1) begin : g_ch_chk
      $fatal(1, "at least one channel required");
   end

   logic [NUM_CH-1:0]       ch_en;
   dmt_pkg::tmr_mode_e      ch_mode [NUM_CH];
   logic [NUM_CH*WIDTH-1:0] ch_period;

   dmt_regs #(.NUM_CH(NUM_CH), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .ch_en     (ch_en),
      .ch_mode   (ch_mode),
      .ch_period (ch_period)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_tmr
      dmt_channel #(.WIDTH(WIDTH)) u_ch (
         .clk    (clk),
         .rst_n  (rst_n),
         .en     (ch_en[i]),
         .mode   (ch_mode[i]),
         .period (ch_period[i*WIDTH +: WIDTH]),
         .tout   (tout[i]),
         .irq    (irq[i])
      );
   end

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (tout == '0 && irq == '0)); // R1
endmodule

// File: tb/dual_mode_timer_test.sv
module dual_mode_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  tout, irq;

   int unsigned n_checks = 0;
   int unsigned n_errors = 0;

   always #4 clk = ~clk;

   dual_mode_timer uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .tout(tout), .irq(irq)
   );

   // bench model: counts cycles up from the load and compares with the period in force
   bit          m_en [2], m_mode [2], m_run [2], m_tout [2], m_irq [2];
   int unsigned m_data [2], m_phase [2], m_per [2];
   bit          model_on = 1'b0;

   function automatic int unsigned eff_period(int unsigned v);
      return (v == 0) ? 1 : v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 2; i++) begin
            m_en[i] = 0; m_mode[i] = 0; m_run[i] = 0; m_tout[i] = 0;
            m_irq[i] = 0; m_data[i] = 0; m_phase[i] = 0; m_per[i] = 1;
         end
      end else begin
         for (int i = 0; i < 2; i++) begin
            if (!m_en[i]) begin
               m_run[i] = 0; m_tout[i] = 0; m_irq[i] = 0;
            end else if (!m_run[i]) begin
               m_run[i] = 1; m_phase[i] = 0; m_per[i] = eff_period(m_data[i]);
               m_tout[i] = 0; m_irq[i] = 0;
            end else begin
               bit hit;
               m_phase[i]++;
               hit = (m_phase[i] == m_per[i]);
               if (hit) begin
                  m_phase[i] = 0;
                  m_per[i] = eff_period(m_data[i]);
               end
               m_irq[i] = hit;
               m_tout[i] = m_mode[i] ? (m_tout[i] ^ hit) : hit;
            end
         end
         if (wr_en) begin
            if (wr_addr == 0) begin
               for (int i = 0; i < 2; i++) begin
                  m_en[i] = wr_data[2*i];
                  m_mode[i] = wr_data[2*i+1];
               end
            end else if (wr_addr <= 2) begin
               m_data[wr_addr-1] = wr_data;
            end
         end
      end
   end

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (model_on && rst_n) begin
         for (int i = 0; i < 2; i++) begin
            string tg;
            if (i == 1) tg = "R8";
            else        tg = m_mode[0] ? "R4" : "R2";
            check({tg, " irq"}, 32'(irq[i]), 32'(m_irq[i]));
            if (i == 0 && m_mode[0]) tg = "R3";
            check({tg, " tout"}, 32'(tout[i]), 32'(m_tout[i]));
         end
      end
   end

   task automatic wr(logic [1:0] a, logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   // counts negedges until irq of channel ch is seen high
   task automatic wait_irq(int ch, output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!irq[ch] && n < 1000);
   endtask

   initial begin
      #(8 * 200000);
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      int g, g2, flips;
      logic prev;
      void'($urandom(32'd1234));
      idle(3);
      check("R1 tout", 32'(tout), 0);
      check("R1 irq", 32'(irq), 0);
      @(negedge clk); rst_n = 1'b1;
      idle(2);
      check("R1 tout after release", 32'(tout), 0);
      model_on = 1'b1;

      // R9 / R2: period 4 on channel 0, interval mode
      wr(2'd1, 32'd4);
      wr(2'd0, 32'b01);
      // enable lands at this edge, load next edge, first pulse period later
      wait_irq(0, g);
      check("R2 first pulse delay", g, 5);
      check("R2 tout with irq", 32'(tout[0]), 1);
      wait_irq(0, g);
      check("R2 gap", g, 4);
      wait_irq(0, g);
      check("R2 gap again", g, 4);

      // R7: new period during a run applies from the next reload
      wr(2'd1, 32'd3);
      wait_irq(0, g);
      check("R7 gap in progress", g + 1, 4);
      wait_irq(0, g2);
      check("R7 gap after reload", g2, 3);

      // R6: disable keeps outputs low
      wr(2'd0, 32'b00);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         check("R6 tout off", 32'(tout[0]), 0);
         check("R6 irq off", 32'(irq[0]), 0);
      end

      // R3 / R4: toggle mode, period 3
      wr(2'd0, 32'b11);
      @(negedge clk);
      check("R3 starts low", 32'(tout[0]), 0);
      flips = 0;
      prev = tout[0];
      for (int k = 0; k < 30; k++) begin
         @(negedge clk);
         if (tout[0] != prev) flips++;
         check("R4 irq on edge", 32'(irq[0]), 32'(tout[0] != prev));
         prev = tout[0];
      end
      check("R3 flip count", flips, 10);

      // R6: re-enable performs a fresh load
      wr(2'd0, 32'b00);
      wr(2'd1, 32'd6);
      wr(2'd0, 32'b01);
      wait_irq(0, g);
      check("R6 fresh load delay", g, 7);

      // R5: period 0 times out every clock
      wr(2'd0, 32'b00);
      wr(2'd1, 32'd0);
      wr(2'd0, 32'b01);
      idle(2);
      flips = 0;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         if (irq[0]) flips++;
      end
      check("R5 pulses per clock", flips, 10);

      // R8: channel 1 runs alongside while channel 0 toggles
      wr(2'd2, 32'd7);
      wr(2'd1, 32'd5);
      wr(2'd0, 32'b0111);
      idle(60);

      // random phase: writes collide with reloads
      for (int k = 0; k < 4000; k++) begin
         if ($urandom_range(0, 11) == 0) begin
            logic [1:0] a;
            logic [31:0] d;
            a = 2'($urandom_range(0, 2));
            if (a == 0) d = {28'd0, 4'($urandom_range(0, 15))};
            else        d = $urandom_range(0, 9);
            wr(a, d);
         end else begin
            @(negedge clk);
         end
      end

      model_on = 1'b0;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule